// File: doc/BRIEF.md
# Dual-Clock FIFO with Five-Level Status

This block is a first-in first-out buffer that sits between two unrelated clock domains. A producer stores 18-bit words on its own write clock and a consumer takes them out on its own read clock. The words live in a dual-port array whose depth is set by an address-width parameter. The standard sizes run from 8K to 64K words. The default is kept smaller so the block elaborates quickly.

Occupancy is reported on five active-low outputs. The empty and almost-empty outputs are updated only by the read clock. The half-full, almost-full and full outputs are updated only by the write clock. Two 16-bit threshold inputs, supplied by a separate programming block, set how close to empty or to full the "almost" outputs switch. A write into a full buffer is dropped, and so is a read from an empty one. The read data register keeps showing the last word that was actually read.

The read and write pointers carry one extra wrap bit. Each pointer crosses into the other domain as Gray code through a two-stage synchroniser. Each side therefore judges the opposite pointer a few cycles late, and that error is always on the safe side.

Top module: `dcfifo_status`

## Requirements
- R1: Words accepted on the write side come out on `dout` in the same order, each appearing after the read-clock edge that accepts its read.
- R2: A write request (`wr_en_n` low) at a write-clock edge where `ff_n` is low stores nothing and does not advance the write side.
- R3: A read request (`rd_en_n` low) at a read-clock edge where `ef_n` is low is dropped, and `dout` keeps its previous value.
- R4: `ff_n` is low exactly when the write side counts DEPTH words stored. That count is the write pointer after the current write-clock edge minus the read pointer as it stood three write-clock edges earlier. With aligned clocks, a read frees space on the third write-clock edge after it.
- R5: `ef_n` is low exactly when the read side counts zero words. That count is the write pointer as it stood three read-clock edges earlier minus the read pointer after the current read-clock edge. With aligned clocks, a write becomes readable on the third read-clock edge after it.
- R6: While `rst_n` is low at a clock edge, both pointers clear and any read or write request is ignored. After that edge, `ef_n` and `pae_n` are low, `hf_n`, `paf_n` and `ff_n` are high, and `dout` is zero.
- R7: `pae_n` is low exactly when the read-side count (as in R5) is less than or equal to the unsigned value on `ae_off`.
- R8: `paf_n` is low exactly when DEPTH minus the write-side count (as in R4) is less than or equal to the unsigned value on `af_off`.
- R9: `hf_n` is low exactly when the write-side count (as in R4) is greater than DEPTH/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously by both clocks |
| wr_en_n | input | 1 | Active-low write request |
| din | input | DW (18) | Word to store |
| rd_en_n | input | 1 | Active-low read request |
| dout | output | DW (18) | Read data register |
| ae_off | input | OW (16) | Almost-empty threshold in words |
| af_off | input | OW (16) | Almost-full threshold in free words |
| ef_n | output | 1 | Empty, active low, read domain |
| pae_n | output | 1 | Almost empty, active low, read domain |
| hf_n | output | 1 | More than half full, active low, write domain |
| paf_n | output | 1 | Almost full, active low, write domain |
| ff_n | output | 1 | Full, active low, write domain |

## Verification
Both clocks come from one 250 MHz source, so every crossing has a fixed latency. A flag or `dout` change caused by its own domain's request is due right after the next edge. A pointer move seen from the other domain counts on the third edge. The bench keeps a per-cycle history of accepted reads and writes and checks every output at the falling edge that follows each rising edge. Expected write-side flags use the current write total against the read total from three cycles back, and expected read-side flags use the reverse. A near-exhaustive sweep over both thresholds on a depth-8 configuration covers fill, drain, overflow, underflow, mixed traffic and a reset taken mid-stream.

// File: rtl/fifo_status_pkg.sv
package fifo_status_pkg;
  localparam int WORD_W  = 18;
  localparam int OFF_W   = 16;
  localparam int ADDR_W  = 12;
endpackage

// File: rtl/ff_gray2bin.sv
module ff_gray2bin #(
  parameter int W = 4
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin[i] = ^gray[W-1:i];
  end
endmodule

// File: rtl/ff_gray_sync.sv
module ff_gray_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ff_dpram.sv
module ff_dpram #(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port; holds its value when no read is accepted
  always_ff @(posedge rclk) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ff_wr_ctl.sv
module ff_wr_ctl #(
  parameter int AW = 4,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [AW:0]   rgray_sync,
  input  logic [OW-1:0] af_off,
  output logic          we,
  output logic [AW:0]   wptr,
  output logic [AW:0]   wgray,
  output logic          full_n,
  output logic          afull_n,
  output logic          half_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] wptr_q, wptr_d, rptr_b, used_d, free_d;

  ff_gray2bin #(.W(PW)) u_rdec (.gray(rgray_sync), .bin(rptr_b));

  assign we     = wr_req && full_n;
  assign wptr_d = wptr_q + PW'(we);
  assign used_d = wptr_d - rptr_b;
  assign free_d = DEPTH_P - used_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      wgray   <= '0;
      full_n  <= 1'b1;
      afull_n <= 1'b1;
      half_n  <= 1'b1;
    end else begin
      wptr_q  <= wptr_d;
      wgray   <= wptr_d ^ (wptr_d >> 1);
      full_n  <= (used_d != DEPTH_P);
      afull_n <= !(32'(free_d) <= 32'(af_off));
      half_n  <= !(32'(used_d) > 32'(HALF));
    end
  end

  assign wptr = wptr_q;
endmodule

// File: rtl/ff_rd_ctl.sv
module ff_rd_ctl #(
  parameter int AW = 4,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW:0]   wgray_sync,
  input  logic [OW-1:0] ae_off,
  output logic          re,
  output logic [AW:0]   rptr,
  output logic [AW:0]   rgray,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rptr_q, rptr_d, wptr_b, used_d;

  ff_gray2bin #(.W(PW)) u_wdec (.gray(wgray_sync), .bin(wptr_b));

  assign re     = rd_req && empty_n;
  assign rptr_d = rptr_q + PW'(re);
  assign used_d = wptr_b - rptr_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr_q   <= '0;
      rgray    <= '0;
      empty_n  <= 1'b0;
      aempty_n <= 1'b0;
    end else begin
      rptr_q   <= rptr_d;
      rgray    <= rptr_d ^ (rptr_d >> 1);
      empty_n  <= (used_d != '0);
      aempty_n <= !(32'(used_d) <= 32'(ae_off));
    end
  end

  assign rptr = rptr_q;
endmodule

// File: rtl/dcfifo_status.sv
module dcfifo_status #(
  parameter int DW = fifo_status_pkg::WORD_W,
  parameter int AW = fifo_status_pkg::ADDR_W,
  parameter int OW = fifo_status_pkg::OFF_W
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic [DW-1:0] din,
  input  logic          rd_en_n,
  output logic [DW-1:0] dout,
  input  logic [OW-1:0] ae_off,
  input  logic [OW-1:0] af_off,
  output logic          ef_n,
  output logic          pae_n,
  output logic          hf_n,
  output logic          paf_n,
  output logic          ff_n
);
  localparam int PW = AW + 1;

  logic          w_we, r_re;
  logic [PW-1:0] w_ptr, w_gray, r_ptr, r_gray;
  logic [PW-1:0] rgray_in_w, wgray_in_r;

  // requests are masked while reset is held
  ff_wr_ctl #(.AW(AW), .OW(OW)) u_wr (
    .clk(wclk), .rst_n(rst_n), .wr_req(!wr_en_n && rst_n),
    .rgray_sync(rgray_in_w), .af_off(af_off),
    .we(w_we), .wptr(w_ptr), .wgray(w_gray),
    .full_n(ff_n), .afull_n(paf_n), .half_n(hf_n)
  );

  ff_rd_ctl #(.AW(AW), .OW(OW)) u_rd (
    .clk(rclk), .rst_n(rst_n), .rd_req(!rd_en_n && rst_n),
    .wgray_sync(wgray_in_r), .ae_off(ae_off),
    .re(r_re), .rptr(r_ptr), .rgray(r_gray),
    .empty_n(ef_n), .aempty_n(pae_n)
  );

  ff_gray_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(r_gray), .q(rgray_in_w));
  ff_gray_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(w_gray), .q(wgray_in_r));

  ff_dpram #(.DW(DW), .AW(AW)) u_mem (
    .wclk(wclk), .we(w_we), .waddr(w_ptr[AW-1:0]), .wdata(din),
    .rclk(rclk), .rst_n(rst_n), .re(r_re), .raddr(r_ptr[AW-1:0]), .rdata(dout)
  );
endmodule

// File: rtl/dcfifo_status_chk.sv
module dcfifo_status_chk #(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          wr_en_n,
  input logic [DW-1:0] dout,
  input logic          ef_n,
  input logic          pae_n,
  input logic          hf_n,
  input logic          paf_n,
  input logic          ff_n,
  input logic [AW:0]   w_ptr,
  input logic [AW:0]   w_gray,
  input logic [AW:0]   r_gray
);
  a_r2_no_write_when_full: assert property (@(posedge wclk) disable iff (!rst_n)
    (!ff_n && !wr_en_n) |=> (w_ptr == $past(w_ptr)));

  a_r3_dout_held_when_empty: assert property (@(posedge rclk) disable iff (!rst_n)
    !ef_n |=> $stable(dout));

  a_r4_wgray_single_step: assert property (@(posedge wclk) disable iff (!rst_n)
    $onehot0(w_gray ^ $past(w_gray)));

  a_r5_rgray_single_step: assert property (@(posedge rclk) disable iff (!rst_n)
    $onehot0(r_gray ^ $past(r_gray)));

  a_r6_write_side_reset: assert property (@(posedge wclk)
    !rst_n |=> (ff_n && paf_n && hf_n));

  a_r6_read_side_reset: assert property (@(posedge rclk)
    !rst_n |=> (!ef_n && !pae_n && dout == '0));

  a_r7_empty_implies_pae: assert property (@(posedge rclk) disable iff (!rst_n)
    !ef_n |-> !pae_n);

  a_r8_full_implies_paf: assert property (@(posedge wclk) disable iff (!rst_n)
    !ff_n |-> !paf_n);

  a_r9_full_implies_hf: assert property (@(posedge wclk) disable iff (!rst_n)
    !ff_n |-> !hf_n);
endmodule

bind dcfifo_status dcfifo_status_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .dout(dout),
  .ef_n(ef_n), .pae_n(pae_n), .hf_n(hf_n), .paf_n(paf_n), .ff_n(ff_n),
  .w_ptr(w_ptr), .w_gray(w_gray), .r_gray(r_gray)
);

// File: tb/dcfifo_status_test.sv
module dcfifo_status_test;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;
  localparam int DW    = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en_n = 1'b1;
  logic          rd_en_n = 1'b1;
  logic [DW-1:0] din = '0;
  logic [15:0]   ae_off = 16'd2;
  logic [15:0]   af_off = 16'd3;
  logic [DW-1:0] dout;
  logic          ef_n, pae_n, hf_n, paf_n, ff_n;

  always #2 clk = ~clk;

  dcfifo_status #(.DW(DW), .AW(AW), .OW(16)) uut (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .din(din),
    .rd_en_n(rd_en_n), .dout(dout), .ae_off(ae_off), .af_off(af_off),
    .ef_n(ef_n), .pae_n(pae_n), .hf_n(hf_n), .paf_n(paf_n), .ff_n(ff_n)
  );

  int checks = 0;
  int fails  = 0;
  int wh [4096];
  int rh [4096];
  int cyc = 0, wtot = 0, rtot = 0, seq = 0;
  logic [DW-1:0] dq [64];
  logic [DW-1:0] last_q = '0;
  logic [15:0]   lf = 16'hACE1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  function automatic int w_at(input int k);
    return (k < 0) ? 0 : wh[k];
  endfunction

  function automatic int r_at(input int k);
    return (k < 0) ? 0 : rh[k];
  endfunction

  task automatic step(input bit wr, input bit rd, input string dtag);
    int wc, rc;
    wr_en_n = ~wr;
    rd_en_n = ~rd;
    din = DW'(seq * 97 + 13);
    seq++;
    if (wr && ff_n) begin dq[wtot % 64] = din; wtot++; end
    if (rd && ef_n) begin last_q = dq[rtot % 64]; rtot++; end
    @(posedge clk);
    @(negedge clk);
    wh[cyc] = wtot;
    rh[cyc] = rtot;
    wc = wtot - r_at(cyc - 3);
    rc = w_at(cyc - 3) - rtot;
    chk("R4 ff_n", 32'(ff_n), 32'(wc != DEPTH));
    chk("R8 paf_n", 32'(paf_n), 32'(!((DEPTH - wc) <= int'(af_off))));
    chk("R9 hf_n", 32'(hf_n), 32'(!(wc > DEPTH / 2)));
    chk("R5 ef_n", 32'(ef_n), 32'(rc != 0));
    chk("R7 pae_n", 32'(pae_n), 32'(!(rc <= int'(ae_off))));
    chk(dtag, 32'(dout), 32'(last_q));
    cyc++;
  endtask

  task automatic do_reset(input int n);
    rst_n = 1'b0;
    wr_en_n = 1'b0;   // requests held active to show R6 masking
    rd_en_n = 1'b0;
    din = '1;
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      chk("R6 ff_n", 32'(ff_n), 32'd1);
      chk("R6 paf_n", 32'(paf_n), 32'd1);
      chk("R6 hf_n", 32'(hf_n), 32'd1);
      chk("R6 ef_n", 32'(ef_n), 32'd0);
      chk("R6 pae_n", 32'(pae_n), 32'd0);
      chk("R6 dout", 32'(dout), 32'd0);
    end
    rst_n = 1'b1;
    wr_en_n = 1'b1;
    rd_en_n = 1'b1;
    wtot = 0; rtot = 0; cyc = 0; last_q = '0;
  endtask

  task automatic fill_drain(input int n);
    repeat (n) step(1'b1, 1'b0, "R2 dout after overflow");
    repeat (4) step(1'b0, 1'b0, "R1 dout");
    repeat (n) step(1'b0, 1'b1, "R1 R3 dout order and hold");
    repeat (4) step(1'b0, 1'b0, "R3 dout");
  endtask

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(3);
    // requests during reset must leave nothing behind (R6)
    repeat (5) step(1'b0, 1'b0, "R6 dout after reset");
    // overflow and underflow with default thresholds (R1, R2, R3)
    fill_drain(DEPTH + 6);
    // threshold sweep (R7, R8)
    for (int off = 0; off <= DEPTH + 1; off++) begin
      ae_off = (off == DEPTH + 1) ? 16'hFFFF : 16'(off);
      af_off = (off == DEPTH + 1) ? 16'hFFFF : 16'(DEPTH - off);
      fill_drain(DEPTH + 2);
    end
    // mixed traffic, four request densities (R1, R4, R5)
    for (int s = 0; s < 4; s++) begin
      ae_off = 16'(s + 1);
      af_off = 16'(3 - s);
      for (int i = 0; i < 150; i++) begin
        bit wr, rd;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        case (s)
          0:       begin wr = (lf[1:0] != 2'd0); rd = (lf[3:2] == 2'd0); end
          1:       begin wr = (lf[1:0] == 2'd0); rd = (lf[3:2] != 2'd0); end
          2:       begin wr = lf[1];             rd = lf[3];             end
          default: begin wr = (lf[1:0] != 2'd0); rd = (lf[3:2] != 2'd0); end
        endcase
        step(wr, rd, "R1 dout mixed");
      end
    end
    // reset taken while holding data (R6)
    repeat (6) step(1'b1, 1'b0, "R1 dout");
    do_reset(2);
    repeat (5) step(1'b0, 1'b1, "R6 R3 dout read after reset");
    ae_off = 16'd2;
    af_off = 16'd3;
    fill_drain(DEPTH + 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule